// File: doc/BRIEF.md
# Speculative Load Confirmation Table

This block tracks loads that a pipeline has moved ahead of older stores. When such an early load issues, the pipeline records it here: the register the load writes, the 8-byte block it read, and which bytes of that block it touched. Every store that executes afterwards is presented on a snoop port. Any tracked load whose bytes overlap the store is dropped.

When the program later reaches the point where the early value is consumed, it presents the destination register on the check port. One cycle later the block answers. A hit means no overlapping store came in between, so the early value may be used. A miss means the load has to be issued again at that point.

The table is fully associative and holds a fixed number of entries. It is searched by register tag for checks and allocations, and by byte range for snoops. When it overflows, the least recently allocated entry is lost. Losing an entry can only turn a hit into a miss. It never turns a miss into a hit.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table holds no entries, `chk_done` and `chk_hit` are low, and any check reports a miss.
- R2: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high. `chk_hit` carries the outcome in that cycle and is low whenever `chk_done` is low.
- R3: A check on a tag that was allocated in an earlier cycle, with no overlapping store since then, reports a hit.
- R4: A snoop removes every entry whose byte range overlaps the store. The access size code 0/1/2/3 means 1/2/4/8 bytes starting at byte offset `addr[2:0]`, and bytes past offset 7 are dropped. Two ranges overlap when `addr[ADDR_W-1:3]` is equal and the byte sets intersect. A later check on a removed entry reports a miss.
- R5: A snoop to the same 8-byte block with disjoint bytes, or to a different block, leaves the entry in place.
- R6: A check removes the entry it examines, so a second check on the same tag without a new allocation reports a miss.
- R7: Allocating a tag that already has an entry replaces that entry's address and size. Only one entry per tag exists, and snoops are compared only against the newest address.
- R8: With all NUM_ENTRIES entries in use, allocating a new tag evicts the least recently allocated entry. A check on the evicted tag reports a miss, while the remaining entries still hit.
- R9: When an allocation and a snoop with overlapping ranges arrive in the same cycle, the snoop acts first, so the new entry survives.
- R10: A check in the same cycle as a snoop sees the snoop's removals. A check in the same cycle as an allocation to the same tag sees the entry as it stood before that allocation, and the new entry is kept.
- R11: A check on a tag that was never allocated reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Record an early load this cycle |
| alloc_tag | input | TAG_W | Destination register of the early load |
| alloc_addr | input | ADDR_W | Byte address of the early load |
| alloc_size | input | 2 | Size code of the early load (0..3 = 1..8 bytes) |
| snoop_valid | input | 1 | A store executes this cycle |
| snoop_addr | input | ADDR_W | Byte address of the store |
| snoop_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Confirm request this cycle |
| chk_tag | input | TAG_W | Register whose early value is to be confirmed |
| chk_done | output | 1 | Confirm result valid (one cycle after request) |
| chk_hit | output | 1 | 1 = early value good, 0 = reload required |

## Verification
Only the confirm outcome has a latency. It is registered once, so `chk_done` and `chk_hit` belong to the request presented one rising edge earlier. All table updates take effect at that same edge, so they are visible to any check presented in the next cycle.

The bench drives inputs just after the falling edge and advances its queue model at once, as if at the coming rising edge. At the next falling edge it compares the outputs against that prediction, which keeps every comparison exactly one register stage after its stimulus. Same-cycle collisions of snoop, check and allocation are driven on purpose to pin down the order in which they apply.

// File: rtl/slt_pkg.sv
package slt_pkg;

    localparam int LINE_BYTES = 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);

    // Bytes touched inside one aligned block; bytes beyond the block end are cut off.
    function automatic logic [LINE_BYTES-1:0] span_mask(input logic [OFF_W-1:0] off,
                                                        input logic [1:0]       size);
        logic [LINE_BYTES-1:0] base;
        base = LINE_BYTES'((32'd1 << (32'd1 << size)) - 32'd1);
        return base << off;
    endfunction

endpackage

// File: rtl/slt_pick.sv
module slt_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/slt_match.sv
module slt_match #(
    parameter int N      = 16,
    parameter int TAG_W  = 6,
    parameter int BLK_W  = 29,
    parameter int MASK_W = 8
) (
    input  logic [TAG_W-1:0]  ent_tag  [N],
    input  logic [BLK_W-1:0]  ent_blk  [N],
    input  logic [MASK_W-1:0] ent_mask [N],
    input  logic [BLK_W-1:0]  snoop_blk,
    input  logic [MASK_W-1:0] snoop_mask,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic [N-1:0]      snoop_ovl,
    output logic [N-1:0]      chk_eq,
    output logic [N-1:0]      alloc_eq
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign snoop_ovl[g] = (ent_blk[g] == snoop_blk) && |(ent_mask[g] & snoop_mask);
        assign chk_eq[g]    = (ent_tag[g] == chk_tag);
        assign alloc_eq[g]  = (ent_tag[g] == alloc_tag);
    end
endmodule

// File: rtl/slt_age.sv
module slt_age #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx,
    output logic [N-1:0]     oldest_vec
);
    typedef struct packed {
        logic [N-1:0][IDX_W-1:0] rank;
    } age_t;

    age_t age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (touch_valid) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_d.rank[i] = '0;
                else if (age_q.rank[i] < age_q.rank[touch_idx])
                    age_d.rank[i] = age_q.rank[i] + 1'b1;
            end
        end
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (age_q.rank[i] == IDX_W'(N - 1));
            if (oldest_vec[i]) oldest_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q.rank[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec)); // R8
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import slt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int TAG_W       = 6,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [1:0]        alloc_size,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [1:0]        snoop_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_done,
    output logic              chk_hit
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int BLK_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic                  valid;
        logic [TAG_W-1:0]      tag;
        logic [BLK_W-1:0]      blk;
        logic [LINE_BYTES-1:0] mask;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_ENTRIES-1:0] ents;
        logic                   done;
        logic                   hit;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]       ent_tag  [NUM_ENTRIES];
    logic [BLK_W-1:0]       ent_blk  [NUM_ENTRIES];
    logic [LINE_BYTES-1:0]  ent_mask [NUM_ENTRIES];

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            valid_q[i]  = st_q.ents[i].valid;
            ent_tag[i]  = st_q.ents[i].tag;
            ent_blk[i]  = st_q.ents[i].blk;
            ent_mask[i] = st_q.ents[i].mask;
        end
    end

    logic [NUM_ENTRIES-1:0] snoop_ovl, chk_eq, alloc_eq;

    slt_match #(
        .N(NUM_ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W), .MASK_W(LINE_BYTES)
    ) u_match (
        .ent_tag    (ent_tag),
        .ent_blk    (ent_blk),
        .ent_mask   (ent_mask),
        .snoop_blk  (snoop_addr[ADDR_W-1:OFF_W]),
        .snoop_mask (span_mask(snoop_addr[OFF_W-1:0], snoop_size)),
        .chk_tag    (chk_tag),
        .alloc_tag  (alloc_tag),
        .snoop_ovl  (snoop_ovl),
        .chk_eq     (chk_eq),
        .alloc_eq   (alloc_eq)
    );

    // Survivors of the snoop, then of the check.
    logic [NUM_ENTRIES-1:0] live_snp, chk_vec, live_chk, own_vec;

    always_comb begin
        live_snp = valid_q & ~(snoop_valid ? snoop_ovl : '0);
        chk_vec  = chk_eq & live_snp;
        live_chk = live_snp & ~(chk_valid ? chk_vec : '0);
        own_vec  = alloc_eq & live_chk;
    end

    logic             own_any, free_any;
    logic [IDX_W-1:0] own_idx, free_idx, oldest_idx, target;
    logic [NUM_ENTRIES-1:0] oldest_vec;

    slt_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_own (
        .req(own_vec), .any(own_any), .idx(own_idx)
    );

    slt_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free (
        .req(~live_chk), .any(free_any), .idx(free_idx)
    );

    always_comb begin
        if (own_any)       target = own_idx;
        else if (free_any) target = free_idx;
        else               target = oldest_idx;
    end

    slt_age #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (alloc_valid),
        .touch_idx   (target),
        .oldest_idx  (oldest_idx),
        .oldest_vec  (oldest_vec)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_ENTRIES; i++) st_d.ents[i].valid = live_chk[i];
        st_d.done = chk_valid;
        st_d.hit  = chk_valid && (|chk_vec);
        if (alloc_valid) begin
            st_d.ents[target].valid = 1'b1;
            st_d.ents[target].tag   = alloc_tag;
            st_d.ents[target].blk   = alloc_addr[ADDR_W-1:OFF_W];
            st_d.ents[target].mask  = span_mask(alloc_addr[OFF_W-1:0], alloc_size);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_done = st_q.done;
    assign chk_hit  = st_q.hit;

    AST_DONE_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done); // R2
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done); // R2
    AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> !chk_hit); // R2
    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_eq & valid_q)); // R7
    AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> (|valid_q)); // R3
    AST_SNOOP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && !alloc_valid) |=>
            ($countones(valid_q) <= $past($countones(valid_q)))); // R4
endmodule

// File: tb/sim_spec_load_table.sv
`timescale 1ns/1ps
module sim_spec_load_table;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, snoop_valid = 1'b0, chk_valid = 1'b0;
    logic [5:0]  alloc_tag = '0, chk_tag = '0;
    logic [31:0] alloc_addr = '0, snoop_addr = '0;
    logic [1:0]  alloc_size = '0, snoop_size = '0;
    logic        chk_done, chk_hit;

    always #10 clk = ~clk;

    spec_load_table #(.NUM_ENTRIES(N), .TAG_W(6), .ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
        .alloc_size(alloc_size),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_size(snoop_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_done(chk_done), .chk_hit(chk_hit)
    );

    typedef struct {
        logic [5:0]  tag;
        logic [28:0] blk;
        logic [7:0]  bytes;
    } rec_t;

    rec_t   mq[$];
    int     total = 0, bad = 0;
    logic   exp_done = 1'b0, exp_hit = 1'b0;
    string  prev_lbl = "R1 reset state";

    function automatic logic [7:0] bytes_of(input logic [31:0] a, input logic [1:0] sz);
        logic [7:0] m = '0;
        int len = 1 << sz;
        for (int b = 0; b < 8; b++)
            if (b >= int'(a[2:0]) && b < int'(a[2:0]) + len) m[b] = 1'b1;
        return m;
    endfunction

    task automatic compare();
        total++;
        if (chk_done !== exp_done || chk_hit !== exp_hit) begin
            bad++;
            $display("FAIL %s: done/hit actual=%b%b expected=%b%b at %0t",
                     prev_lbl, chk_done, chk_hit, exp_done, exp_hit, $time);
        end
    endtask

    task automatic step(input logic av, input logic [5:0] at, input logic [31:0] aa,
                        input logic [1:0] asz, input logic sv, input logic [31:0] sa,
                        input logic [1:0] ssz, input logic cv, input logic [5:0] ct,
                        input string lbl);
        logic [7:0] sb;
        @(negedge clk);
        compare();
        alloc_valid = av; alloc_tag = at; alloc_addr = aa; alloc_size = asz;
        snoop_valid = sv; snoop_addr = sa; snoop_size = ssz;
        chk_valid = cv;   chk_tag = ct;
        // model: snoop, then check, then allocate
        if (sv) begin
            sb = bytes_of(sa, ssz);
            for (int k = mq.size() - 1; k >= 0; k--)
                if (mq[k].blk == sa[31:3] && (mq[k].bytes & sb) != 0) mq.delete(k);
        end
        exp_done = cv;
        exp_hit  = 1'b0;
        if (cv) begin
            for (int k = mq.size() - 1; k >= 0; k--)
                if (mq[k].tag == ct) begin exp_hit = 1'b1; mq.delete(k); end
        end
        if (av) begin
            rec_t r;
            for (int k = mq.size() - 1; k >= 0; k--)
                if (mq[k].tag == at) mq.delete(k);
            if (mq.size() == N) void'(mq.pop_front());
            r.tag = at; r.blk = aa[31:3]; r.bytes = bytes_of(aa, asz);
            mq.push_back(r);
        end
        prev_lbl = lbl;
    endtask

    task automatic alloc(input logic [5:0] t, input logic [31:0] a, input logic [1:0] s,
                         input string lbl);
        step(1, t, a, s, 0, 0, 0, 0, 0, lbl);
    endtask
    task automatic snoop(input logic [31:0] a, input logic [1:0] s, input string lbl);
        step(0, 0, 0, 0, 1, a, s, 0, 0, lbl);
    endtask
    task automatic check(input logic [5:0] t, input string lbl);
        step(0, 0, 0, 0, 0, 0, 0, 1, t, lbl);
    endtask
    task automatic idle(input string lbl);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, lbl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset outputs low");
        check(6'd5, "R1 R11 check on empty table");
        idle("R2 done drops after check");
        // R3 plain hit
        alloc(6'd1, 32'h100, 2'd3, "R3 alloc");
        check(6'd1, "R3 hit without store");
        idle("R3 result");
        // R5 disjoint stores
        alloc(6'd2, 32'h200, 2'd2, "R5 alloc");
        snoop(32'h204, 2'd2, "R5 disjoint bytes same block");
        snoop(32'h208, 2'd3, "R5 other block");
        check(6'd2, "R5 entry kept");
        // R4 partial overlap
        alloc(6'd3, 32'h302, 2'd1, "R4 alloc");
        snoop(32'h303, 2'd0, "R4 single byte overlap");
        check(6'd3, "R4 miss after overlap");
        // R4 truncated span: 8-byte store at offset 7 covers only byte 7
        alloc(6'd4, 32'h400, 2'd2, "R4 alloc low bytes");
        snoop(32'h407, 2'd3, "R4 span cut at block end");
        check(6'd4, "R4 cut span misses nothing");
        // R6 consume
        alloc(6'd6, 32'h600, 2'd0, "R6 alloc");
        check(6'd6, "R6 first check");
        check(6'd6, "R6 second check");
        idle("R6 second check misses");
        // R7 overwrite
        alloc(6'd7, 32'h700, 2'd3, "R7 alloc old");
        alloc(6'd7, 32'h780, 2'd3, "R7 alloc new");
        snoop(32'h700, 2'd3, "R7 store to old address");
        check(6'd7, "R7 hit on new address");
        alloc(6'd7, 32'h780, 2'd3, "R7 alloc again");
        snoop(32'h784, 2'd0, "R7 store to new address");
        check(6'd7, "R7 miss on new address");
        // R8 fill and evict
        for (int i = 0; i < N; i++) alloc(6'(10 + i), 32'h1000 + 32'(i * 8), 2'd3, "R8 fill");
        alloc(6'd40, 32'h2000, 2'd3, "R8 overflow");
        check(6'd10, "R8 evicted oldest misses");
        check(6'd11, "R8 next oldest still hits");
        check(6'd40, "R8 newest hits");
        // R9 alloc and snoop same cycle
        step(1, 6'd41, 32'h3000, 2'd3, 1, 32'h3000, 2'd3, 0, 0, "R9 alloc with snoop");
        check(6'd41, "R9 new entry survives");
        // R10 snoop with check, then check with alloc
        alloc(6'd42, 32'h3100, 2'd2, "R10 alloc");
        step(0, 0, 0, 0, 1, 32'h3102, 2'd0, 1, 6'd42, "R10 snoop seen by check");
        alloc(6'd43, 32'h3200, 2'd2, "R10 alloc 43");
        step(1, 6'd43, 32'h3300, 2'd2, 0, 0, 0, 1, 6'd43, "R10 check sees prior entry");
        check(6'd43, "R10 new entry kept");
        check(6'd63, "R11 unknown tag");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 2) == 0, 6'($urandom_range(0, 19)),
                 32'h5000 + 32'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 3) == 0, 32'h5000 + 32'($urandom_range(0, 63)),
                 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1) == 0, 6'($urandom_range(0, 19)),
                 "R3/R4/R5/R6/R7/R8 random mix");
        end
        idle("R2 final");
        idle("R2 final idle");
        @(negedge clk);
        compare();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule